// File: doc/BRIEF.md
# Stepwise Operating-Mode Request Sequencer

This block sits between a register bus and a power/clock manager. Software writes a 2-bit operating-mode request into a register. The block checks the request and passes it to the manager through a request/acknowledge handshake. A read-only register shows the granted mode, and that mode is the block's current operating mode.

Each mode also selects a supply state for the manager: either the low-power supply or an active supply. The four modes lie on a fixed line. Software may move only to a direct neighbour on that line, in either direction, and only after the previous request has been granted. A write that breaks either rule is dropped and sets a sticky error flag. Software clears that flag by writing 1 to it.

Top module: `opmode_stepper`

## Requirements
- R1: After reset, `cur_mode` is 0, `mgr_req_valid` and `err_flag` are low, and the request word (word 0) and the grant word (word 1) both read 0.
- R2: The modes are encoded as 0 = active, 1 = low-power, 2 = powerdown-active and 3 = powerdown-low-power. The chain is 2 - 0 - 1 - 3. A word-0 write is accepted when the system is idle, its bits 1:0 name a neighbour of `cur_mode` on the chain, and its bits 31:2 are zero. After an accepted write, `mgr_req_valid` rises on the next cycle with `mgr_req_mode` equal to the written mode.
- R3: An idle word-0 write whose mode is not a chain neighbour of `cur_mode` (and is not `cur_mode` itself) is dropped and sets `err_flag`.
- R4: A word-0 write made while a handshake is pending is dropped and sets `err_flag`. Word 0 keeps the pending mode.
- R5: While `mgr_req_valid` is high and `mgr_ack` is low, `mgr_req_valid` stays high and `mgr_req_mode` and `mgr_supply_active` do not change.
- R6: When `mgr_ack` is high during a pending request, on the next cycle `cur_mode` and word 1 equal the requested mode and `mgr_req_valid` is low.
- R7: `mgr_supply_active` is 1 for modes 0 and 1 and is 0 for modes 2 and 3. It follows the mode presented on `mgr_req_mode`.
- R8: `err_flag` stays set until a word-2 write with bit 0 = 1. A word-2 write with bit 0 = 0 leaves it unchanged. Word 2 bit 0 reads the flag.
- R9: Word 1 is read-only. A write to it changes neither `cur_mode` nor its readback.
- R10: `mgr_ack` asserted while no request is pending has no effect on `cur_mode` or `mgr_req_valid`.
- R11: An idle word-0 write of the current mode starts no handshake and sets no error.
- R12: Reads are registered. `rd_data` shows the word selected by `rd_addr` one cycle later. Unused bits read 0, and word 3 reads 0.
- R13: A word-0 write with any of bits 31:2 set is dropped and sets `err_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Word address of the read |
| rd_data | output | 32 | Registered read data |
| mgr_req_valid | output | 1 | A mode request is pending at the manager |
| mgr_req_mode | output | 2 | Requested mode |
| mgr_supply_active | output | 1 | Supply state for the requested mode: 1 = active, 0 = low-power |
| mgr_ack | input | 1 | Manager grants the pending request |
| cur_mode | output | 2 | Granted (current) operating mode |
| err_flag | output | 1 | Sticky rule-violation flag |

## Verification
The checker evaluates these properties on every cycle:
- a raised request always names a chain neighbour of the current mode;
- a pending request holds steady until it is acknowledged;
- a grant copies the requested mode into `cur_mode` and ends the handshake;
- a stray acknowledge, or any cycle without a grant, leaves the mode unchanged;
- a pending-time write or a step-skipping write sets the error flag;
- the supply output matches the mode being requested.

Other behaviour can only be shown by the bench's directed scenarios:
- a full walk along the chain in both directions under different manager latencies;
- the register readback and its one-cycle latency;
- the write-1-to-clear behaviour of the flag;
- the no-op write of the current mode;
- rejection of writes with reserved bits set.

// File: rtl/opmode_pkg.sv
package opmode_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_ACT  = 2'd0,
    MODE_LP   = 2'd1,
    MODE_PDA  = 2'd2,
    MODE_PDLP = 2'd3
  } opmode_e;

  // position of a mode on the linear chain PDA - ACT - LP - PDLP
  function automatic int chain_pos(logic [MODE_W-1:0] m);
    case (m)
      MODE_PDA: return 0;
      MODE_ACT: return 1;
      MODE_LP:  return 2;
      default:  return 3;
    endcase
  endfunction

  function automatic logic is_neighbour(logic [MODE_W-1:0] a, logic [MODE_W-1:0] b);
    int pa;
    int pb;
    pa = chain_pos(a);
    pb = chain_pos(b);
    return (pa == pb + 1) || (pb == pa + 1);
  endfunction

  function automatic logic wants_active_supply(logic [MODE_W-1:0] m);
    return (m == MODE_ACT) || (m == MODE_LP);
  endfunction
endpackage

// File: rtl/opmode_chain_rule.sv
module opmode_chain_rule
  import opmode_pkg::*;
(
  input  logic [MODE_W-1:0] cur_mode,
  input  logic [MODE_W-1:0] want_mode,
  output logic              step_ok,
  output logic              same_mode,
  output logic              want_supply_act
);
  always_comb begin
    step_ok         = is_neighbour(cur_mode, want_mode);
    same_mode       = (cur_mode == want_mode);
    want_supply_act = wants_active_supply(want_mode);
  end
endmodule

// File: rtl/opmode_handshake.sv
module opmode_handshake
  import opmode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [MODE_W-1:0] new_mode,
  input  logic              new_supply_act,
  input  logic              mgr_ack,
  output logic              pending,
  output logic [MODE_W-1:0] req_mode,
  output logic              supply_act,
  output logic [MODE_W-1:0] ack_mode
);
  // reset mode 0 = active, so the supply output starts active
  always_ff @(posedge clk) begin
    if (rst) begin
      pending    <= 1'b0;
      req_mode   <= '0;
      supply_act <= 1'b1;
      ack_mode   <= '0;
    end else if (pending) begin
      if (mgr_ack) begin
        pending  <= 1'b0;
        ack_mode <= req_mode;
      end
    end else if (accept) begin
      pending    <= 1'b1;
      req_mode   <= new_mode;
      supply_act <= new_supply_act;
    end
  end
endmodule

// File: rtl/opmode_csr.sv
module opmode_csr
  import opmode_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [MODE_W-1:0] req_mode,
  input  logic [MODE_W-1:0] ack_mode,
  input  logic              pending,
  input  logic              step_ok,
  input  logic              same_mode,
  output logic [MODE_W-1:0] want_mode,
  output logic              accept,
  output logic              err_flag,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] OFS_REQ = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_ACK = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFS_ERR = ADDR_W'(2);

  logic req_wr;
  logic rsvd_set;
  logic violation;
  logic clr_wr;

  always_comb begin
    want_mode = wr_data[MODE_W-1:0];
    req_wr    = wr_en && (wr_addr == OFS_REQ);
    rsvd_set  = |wr_data[DATA_W-1:MODE_W];
    accept    = req_wr && !pending && !rsvd_set && step_ok;
    violation = req_wr && (pending || rsvd_set || (!step_ok && !same_mode));
    clr_wr    = wr_en && (wr_addr == OFS_ERR) && wr_data[0];
  end

  // a new violation takes priority over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)            err_flag <= 1'b0;
    else if (violation) err_flag <= 1'b1;
    else if (clr_wr)    err_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      case (rd_addr)
        OFS_REQ: rd_data[MODE_W-1:0] <= req_mode;
        OFS_ACK: rd_data[MODE_W-1:0] <= ack_mode;
        OFS_ERR: rd_data[0]          <= err_flag;
        default: rd_data             <= '0;
      endcase
    end
  end
endmodule

// File: rtl/opmode_stepper.sv
module opmode_stepper
  import opmode_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              mgr_req_valid,
  output logic [MODE_W-1:0] mgr_req_mode,
  output logic              mgr_supply_active,
  input  logic              mgr_ack,
  output logic [MODE_W-1:0] cur_mode,
  output logic              err_flag
);
  logic [MODE_W-1:0] want_mode;
  logic              step_ok;
  logic              same_mode;
  logic              want_supply;
  logic              accept;

  opmode_chain_rule u_rule (
    .cur_mode        (cur_mode),
    .want_mode       (want_mode),
    .step_ok         (step_ok),
    .same_mode       (same_mode),
    .want_supply_act (want_supply)
  );

  opmode_handshake u_hs (
    .clk            (clk),
    .rst            (rst),
    .accept         (accept),
    .new_mode       (want_mode),
    .new_supply_act (want_supply),
    .mgr_ack        (mgr_ack),
    .pending        (mgr_req_valid),
    .req_mode       (mgr_req_mode),
    .supply_act     (mgr_supply_active),
    .ack_mode       (cur_mode)
  );

  opmode_csr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_csr (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .req_mode  (mgr_req_mode),
    .ack_mode  (cur_mode),
    .pending   (mgr_req_valid),
    .step_ok   (step_ok),
    .same_mode (same_mode),
    .want_mode (want_mode),
    .accept    (accept),
    .err_flag  (err_flag),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/opmode_stepper_chk.sv
module opmode_stepper_chk
  import opmode_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              mgr_req_valid,
  input logic [MODE_W-1:0] mgr_req_mode,
  input logic              mgr_supply_active,
  input logic              mgr_ack,
  input logic [MODE_W-1:0] cur_mode,
  input logic              err_flag
);
  a_r2_step_is_neighbour: assert property (@(posedge clk) disable iff (rst)
    $rose(mgr_req_valid) |-> is_neighbour(cur_mode, mgr_req_mode));

  a_r3_skip_sets_error: assert property (@(posedge clk) disable iff (rst)
    (!mgr_req_valid && wr_en && wr_addr == '0 &&
     !is_neighbour(cur_mode, wr_data[MODE_W-1:0]) &&
     wr_data[MODE_W-1:0] != cur_mode) |=> err_flag);

  a_r4_busy_write_sets_error: assert property (@(posedge clk) disable iff (rst)
    (mgr_req_valid && wr_en && wr_addr == '0) |=> err_flag);

  a_r5_request_held: assert property (@(posedge clk) disable iff (rst)
    (mgr_req_valid && !mgr_ack) |=>
      (mgr_req_valid && $stable(mgr_req_mode) && $stable(mgr_supply_active)));

  a_r6_grant_updates_mode: assert property (@(posedge clk) disable iff (rst)
    (mgr_req_valid && mgr_ack) |=>
      (!mgr_req_valid && cur_mode == $past(mgr_req_mode)));

  a_r10_mode_only_on_grant: assert property (@(posedge clk) disable iff (rst)
    !(mgr_req_valid && mgr_ack) |=> $stable(cur_mode));

  a_r7_supply_matches_mode: assert property (@(posedge clk) disable iff (rst)
    mgr_req_valid |-> (mgr_supply_active == (mgr_req_mode inside {2'd0, 2'd1})));
endmodule

bind opmode_stepper opmode_stepper_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk               (clk),
  .rst               (rst),
  .wr_en             (wr_en),
  .wr_addr           (wr_addr),
  .wr_data           (wr_data),
  .mgr_req_valid     (mgr_req_valid),
  .mgr_req_mode      (mgr_req_mode),
  .mgr_supply_active (mgr_supply_active),
  .mgr_ack           (mgr_ack),
  .cur_mode          (cur_mode),
  .err_flag          (err_flag)
);

// File: tb/opmode_stepper_tb_top.sv
module opmode_stepper_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        mgr_req_valid;
  logic [1:0]  mgr_req_mode;
  logic        mgr_supply_active;
  logic        mgr_ack = 1'b0;
  logic [1:0]  cur_mode;
  logic        err_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  opmode_stepper dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .mgr_req_valid(mgr_req_valid),
    .mgr_req_mode(mgr_req_mode), .mgr_supply_active(mgr_supply_active),
    .mgr_ack(mgr_ack), .cur_mode(cur_mode), .err_flag(err_flag)
  );

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    cyc();
    d = rd_data;
  endtask

  function automatic logic sup(logic [1:0] m);
    return (m == 2'd0) || (m == 2'd1);
  endfunction

  // R2/R5/R6/R7: one accepted step granted after lat cycles
  task automatic step(logic [1:0] m, int lat);
    logic [31:0] d;
    wr(2'd0, {30'd0, m});
    chk("R2 valid", mgr_req_valid, 1);
    chk("R2 mode", mgr_req_mode, m);
    chk("R7 supply", mgr_supply_active, sup(m));
    for (int i = 0; i < lat; i++) cyc();
    chk("R5 held valid", mgr_req_valid, 1);
    chk("R5 held mode", mgr_req_mode, m);
    mgr_ack = 1'b1;
    cyc();
    mgr_ack = 1'b0;
    chk("R6 valid drop", mgr_req_valid, 0);
    chk("R6 cur_mode", cur_mode, m);
    rd(2'd1, d);
    chk("R6 grant word", d, {30'd0, m});
  endtask

  task automatic clear_err();
    wr(2'd2, 32'd1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 cur_mode", cur_mode, 0);
    chk("R1 valid", mgr_req_valid, 0);
    chk("R1 err", err_flag, 0);
    rd(2'd0, d); chk("R1 req word", d, 0);
    rd(2'd1, d); chk("R1 grant word", d, 0);
    rd(2'd3, d); chk("R12 word3", d, 0);
  endtask

  task automatic t_walk();
    step(2'd1, 0);
    step(2'd3, 3);
    step(2'd1, 1);
    step(2'd0, 5);
    step(2'd2, 2);
    chk("R7 pd supply", mgr_supply_active, 0);
    step(2'd0, 0);
    chk("R2 no err", err_flag, 0);
  endtask

  task automatic t_skip();
    // cur = 0 (active); 3 is two steps away
    wr(2'd0, 32'd3);
    chk("R3 no valid", mgr_req_valid, 0);
    chk("R3 err", err_flag, 1);
    chk("R3 mode kept", cur_mode, 0);
    clear_err();
    chk("R8 cleared", err_flag, 0);
    step(2'd2, 1);
    wr(2'd0, 32'd1);  // PDA -> LP skips
    chk("R3 skip2 err", err_flag, 1);
    chk("R3 skip2 mode", cur_mode, 2);
    clear_err();
    step(2'd0, 0);
  endtask

  task automatic t_busy();
    logic [31:0] d;
    wr(2'd0, 32'd1);
    wr(2'd0, 32'd3);
    chk("R4 err", err_flag, 1);
    chk("R4 mode kept", mgr_req_mode, 1);
    rd(2'd0, d); chk("R4 req word", d, 1);
    mgr_ack = 1'b1; cyc(); mgr_ack = 1'b0;
    chk("R4 granted", cur_mode, 1);
    clear_err();
    step(2'd0, 0);
  endtask

  task automatic t_err_sticky();
    logic [31:0] d;
    wr(2'd0, 32'd3);
    cyc(); cyc();
    chk("R8 sticky", err_flag, 1);
    wr(2'd2, 32'hFFFF_FFFE);
    chk("R8 zero write", err_flag, 1);
    rd(2'd2, d); chk("R8 readback", d, 1);
    wr(2'd2, 32'd1);
    chk("R8 clear", err_flag, 0);
    rd(2'd2, d); chk("R12 err word", d, 0);
  endtask

  task automatic t_ro_grant();
    logic [31:0] d;
    wr(2'd1, 32'd1);
    chk("R9 cur_mode", cur_mode, 0);
    chk("R9 no valid", mgr_req_valid, 0);
    rd(2'd1, d); chk("R9 grant word", d, 0);
  endtask

  task automatic t_stray_ack();
    mgr_ack = 1'b1; cyc(); cyc(); mgr_ack = 1'b0;
    chk("R10 cur_mode", cur_mode, 0);
    chk("R10 valid", mgr_req_valid, 0);
  endtask

  task automatic t_same();
    wr(2'd0, 32'd0);
    chk("R11 no valid", mgr_req_valid, 0);
    chk("R11 no err", err_flag, 0);
  endtask

  task automatic t_reserved();
    wr(2'd0, 32'h0000_0005);  // mode 1 with bit 2 set
    chk("R13 no valid", mgr_req_valid, 0);
    chk("R13 err", err_flag, 1);
    chk("R13 mode", cur_mode, 0);
    clear_err();
  endtask

  task automatic t_read_latency();
    logic [31:0] d;
    step(2'd1, 0);
    rd_addr = 2'd3;
    cyc();
    rd_addr = 2'd1;
    #1;
    chk("R12 latency", rd_data, 0);
    cyc();
    chk("R12 after edge", rd_data, 1);
    step(2'd0, 0);
    rd(2'd0, d); chk("R12 req word", d, 0);
  endtask

  initial begin
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    t_reset();
    t_walk();
    t_skip();
    t_busy();
    t_err_sticky();
    t_ro_grant();
    t_stray_ack();
    t_same();
    t_reserved();
    t_read_latency();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule